// File: doc/BRIEF.md
# I2C Slave Register File

This block puts an I2C slave port in front of a small byte-wide register RAM that lives inside the block. A fast system clock oversamples SCL and SDA. The block finds START, repeated START and STOP conditions on the bus and answers to one 7-bit device address. It keeps a word pointer that selects the RAM location. A master sets the pointer with a write, then either writes bytes in sequence or reads them back after a repeated START.

SDA is open-drain. The block pulls the line low while `sda_oe` is high and otherwise leaves it released. SCL is only an input, and the block never stretches the clock. A read that has no address write before it resumes from wherever the pointer was left. The block has no streaming port: all data moves over the two bus wires, and the RAM port stays inside the block.

Top module: `i2cs_regfile`

## Requirements
- R1: After reset, `sda_oe` is 0, every RAM byte is 0x00 and the pointer is 0.
- R2: A falling SDA while SCL is high (START, repeated or not) restarts address reception. A rising SDA while SCL is high (STOP) returns the block to idle. A repeated START in the middle of a write begins a new transaction that can reload the pointer.
- R3: The first byte after START is {7-bit address, direction bit}, sent MSB first, where direction 1 means read. When the address equals `DEV_ADDR`, the block acknowledges by holding SDA low through the ninth clock.
- R4: When the address does not match, the block never drives SDA and ignores every later byte until the next START or STOP. Bytes sent in that state are not stored.
- R5: In a write, the byte after the address byte is acknowledged, and its low `AW` bits load the pointer.
- R6: Each further write byte is acknowledged and stored at the pointer. The pointer then advances by one at the end of the acknowledge clock, wrapping from 2^AW-1 to 0.
- R7: After a read address is acknowledged, the block sends the byte at the pointer, MSB first, one bit per SCL period.
- R8: When the master acknowledges a read byte (SDA low on the ninth clock), the pointer advances by one with wrap, and the next byte goes out straight away.
- R9: When the master does not acknowledge a read byte, the block releases SDA, leaves the pointer unchanged and waits for STOP or START.
- R10: A read that has no word-address write before it starts at the pointer left by the previous access.
- R11: `sda_oe` changes only while SCL is low, and no earlier than `HOLD_CYC` clock cycles after SCL falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench checks the pointer at the edges of its range. A write burst starts at the last location, and a design that fails to wrap would put the second byte in the wrong place. It checks that a master NACK leaves the pointer alone by issuing a current-address read after it; a design that advanced on every byte would return the next location instead. It sends a wrong device address followed by a data byte, and a design that kept listening would acknowledge or store that byte. It also measures how long after each SCL fall SDA changes. A design with no hold delay would show a gap of only a few cycles.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // transaction phase of the slave
  typedef enum logic [2:0] {
    M_IDLE,
    M_ADDR,
    M_WADDR,
    M_WDATA,
    M_READ,
    M_SKIP
  } mode_t;
endpackage

// File: rtl/i2cs_busmon.sv
// Synchronises both bus lines and derives edge and condition strobes.
module i2cs_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s    = scl_sh[SYNC_STAGES-1];
  assign sda_s    = sda_sh[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_ram.sv
// Small register RAM: one write port, combinational read.
module i2cs_ram #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2cs_sdadrv.sv
// Applies a new SDA drive value only after a hold delay from the SCL fall.
module i2cs_sdadrv #(
  parameter int HOLD_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic val,
  input  logic clr,
  output logic oe
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] cnt;
  logic          pv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pv  <= 1'b0;
      oe  <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      pv  <= 1'b0;
      oe  <= 1'b0;
    end else if (load) begin
      cnt <= HW'(HOLD_CYC);
      pv  <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == HW'(1)) oe <= pv;
    end
  end
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         AW          = 3,
  parameter int         HOLD_CYC    = 20,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam logic [3:0] SLOT_ACK = 4'd8;
  localparam logic [3:0] SLOT_END = 4'd9;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  mode_t mode;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx, rdata;
  logic          rw, mack, pend, addr_hit, active;
  logic          byte_done, ack_end, bit_fall, ram_we;
  logic [AW-1:0] ptr, raddr;

  i2cs_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign active    = (mode != M_IDLE) && (mode != M_SKIP);
  assign addr_hit  = (sh[7:1] == DEV_ADDR);
  assign byte_done = active && scl_fall && (cnt == SLOT_ACK);
  assign ack_end   = active && scl_fall && (cnt == SLOT_END);
  assign bit_fall  = active && scl_fall && (cnt != 4'd0) && (cnt < SLOT_ACK);
  assign ram_we    = ack_end && (mode == M_WDATA);
  assign raddr     = (mode == M_READ) ? AW'(ptr + 1'b1) : ptr;

  i2cs_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ptr), .wdata(sh),
    .raddr(raddr), .rdata(rdata)
  );

  // drive level for the bit slot that follows this SCL fall
  always_comb begin
    pend = 1'b0;
    if (byte_done)
      pend = (mode == M_ADDR && addr_hit) || (mode == M_WADDR) || (mode == M_WDATA);
    else if (ack_end)
      pend = ((mode == M_ADDR && rw) || (mode == M_READ && mack)) && !rdata[7];
    else if (bit_fall && mode == M_READ)
      pend = !tx[6];
  end

  i2cs_sdadrv #(.HOLD_CYC(HOLD_CYC)) u_drv (
    .clk(clk), .rst_n(rst_n), .load(scl_fall), .val(pend),
    .clr(start_ev | stop_ev), .oe(sda_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE;
      cnt  <= '0;
      sh   <= '0;
      tx   <= '0;
      rw   <= 1'b0;
      mack <= 1'b0;
      ptr  <= '0;
    end else if (start_ev) begin
      mode <= M_ADDR;
      cnt  <= '0;
    end else if (stop_ev) begin
      mode <= M_IDLE;
      cnt  <= '0;
    end else if (active) begin
      if (scl_rise) begin
        if (cnt < SLOT_ACK) sh <= {sh[6:0], sda_s};
        if (cnt == SLOT_ACK) mack <= ~sda_s;
        if (cnt < SLOT_END) cnt <= cnt + 1'b1;
      end
      if (byte_done && mode == M_ADDR) begin
        if (addr_hit) rw <= sh[0];
        else          mode <= M_SKIP;
      end
      if (bit_fall && mode == M_READ) tx <= {tx[6:0], 1'b0};
      if (ack_end) begin
        cnt <= '0;
        case (mode)
          M_ADDR: begin
            mode <= rw ? M_READ : M_WADDR;
            if (rw) tx <= rdata;
          end
          M_WADDR: begin
            ptr  <= sh[AW-1:0];
            mode <= M_WDATA;
          end
          M_WDATA: ptr <= ptr + 1'b1;
          M_READ: begin
            if (mack) begin
              ptr <= ptr + 1'b1;
              tx  <= rdata;
            end else begin
              mode <= M_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regfile_chk.sv
module i2cs_regfile_chk
  import i2cs_pkg::*;
#(
  parameter int AW       = 3,
  parameter int HOLD_CYC = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          stop_ev,
  input mode_t         mode,
  input logic [AW-1:0] ptr
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lowcnt <= '0;
    else if (scl_i)                lowcnt <= '0;
    else if (lowcnt != HW'(HOLD_CYC)) lowcnt <= lowcnt + 1'b1;
  end

  // R11
  hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> (!scl_i && lowcnt >= HW'(HOLD_CYC)));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(ptr) && $past(mode) != M_WADDR) |-> (ptr == AW'($past(ptr) + 1'b1)));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (mode == M_IDLE));

  // R4
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SKIP) |-> !sda_oe);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (mode != M_IDLE));
endmodule

bind i2cs_regfile i2cs_regfile_chk #(.AW(AW), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .stop_ev(stop_ev), .mode(mode), .ptr(ptr)
);

// File: tb/sim_i2cs_regfile.sv
module sim_i2cs_regfile;
  localparam int Q = 30;
  localparam int HOLD = 20;
  localparam logic [6:0] DEV = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int errs = 0;
  int checks = 0;
  logic [7:0] got [4];

  assign sda_bus = m_sda & ~sda_oe;
  always #10 clk = ~clk;

  i2cs_regfile #(.DEV_ADDR(DEV), .AW(3), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  // timing monitor for SDA changes relative to SCL falls
  int since_fall = 1000;
  int min_gap = 1000000;
  int bad_high = 0;
  logic scl_d = 1'b1;
  logic oe_d = 1'b0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (scl_d && !scl) since_fall = 0;
      else since_fall++;
      if (sda_oe !== oe_d) begin
        if (scl) bad_high++;
        else if (since_fall < min_gap) min_gap = since_fall;
      end
    end
    scl_d = scl;
    oe_d = sda_oe;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    scl = 1'b1; wq(); wq();
    m_sda = 1'b0; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    scl = 1'b1; wq(); wq();
    m_sda = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    ack = (sda_bus == 1'b0);
    wq();
    scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq();
      scl = 1'b1; wq();
      b[i] = sda_bus;
      wq();
      scl = 1'b0; wq();
    end
    m_sda = ~mack; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic write_bytes(input logic [2:0] a, input logic [7:0] d0, d1, d2, input int n);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R3 write address ack", ack, 1);
    send_byte({5'd0, a}, ack);   chk("R5 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); chk("R6 data ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_random(input logic [2:0] a, input int n);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R3 address ack", ack, 1);
    send_byte({5'd0, a}, ack);   chk("R5 word address ack", ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R3 read address ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, got[i]);
    bus_stop();
  endtask

  task automatic read_current(input int n);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R10 read address ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, got[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda released after reset", sda_oe, 0);
    read_current(1);
    chk("R1 R10 pointer and RAM cleared", got[0], 8'h00);
  endtask

  task automatic t_write_read();
    write_bytes(3'd3, 8'hA0, 8'hA1, 8'hA2, 3);
    read_random(3'd3, 3);
    chk("R7 first byte at pointer", got[0], 8'hA0);
    chk("R8 second byte after master ack", got[1], 8'hA1);
    chk("R8 third byte after master ack", got[2], 8'hA2);
  endtask

  task automatic t_wrap();
    write_bytes(3'd7, 8'h77, 8'h88, 8'h00, 2);
    read_random(3'd7, 2);
    chk("R6 byte at last location", got[0], 8'h77);
    chk("R6 R8 pointer wraps to 0", got[1], 8'h88);
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    send_byte({7'h53, 1'b0}, ack); chk("R4 no ack on wrong address", ack, 0);
    send_byte(8'h02, ack);         chk("R4 byte ignored", ack, 0);
    send_byte(8'h99, ack);         chk("R4 data ignored", ack, 0);
    bus_stop();
    read_random(3'd2, 1);
    chk("R4 location untouched", got[0], 8'h00);
  endtask

  task automatic t_nack();
    read_random(3'd4, 1);
    chk("R7 random read", got[0], 8'hA1);
    read_current(1);
    chk("R9 R10 nack keeps pointer", got[0], 8'hA1);
    read_current(2);
    chk("R10 current read first", got[0], 8'hA1);
    chk("R8 current read second", got[1], 8'hA2);
    read_current(1);
    chk("R9 pointer after ack then nack", got[0], 8'hA2);
  endtask

  task automatic t_rstart();
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R3 ack", ack, 1);
    send_byte(8'h06, ack);       chk("R5 ack", ack, 1);
    send_byte(8'h66, ack);       chk("R6 ack", ack, 1);
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R2 ack after repeated start", ack, 1);
    send_byte(8'h01, ack);       chk("R2 reload ack", ack, 1);
    send_byte(8'h11, ack);       chk("R2 data ack", ack, 1);
    bus_stop();
    read_random(3'd6, 1);
    chk("R2 first transaction byte", got[0], 8'h66);
    read_random(3'd1, 1);
    chk("R2 reloaded pointer byte", got[0], 8'h11);
  endtask

  task automatic t_hold();
    chk("R11 sda change never with scl high", bad_high, 0);
    chk("R11 hold after scl fall", (min_gap >= HOLD) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_wrap();
    t_mismatch();
    t_nack();
    t_rstart();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule